// File: doc/BRIEF.md
# Burst Routing Crossbar with Tail-Bit Teardown

This block is an N-by-N switch that carries variable-length bursts from any input port to any output port. A burst is a run of data words. The last word of a burst has its tail flag set. Each input port also supplies a destination index, which selects the output port for the burst. The switch reads that index only when the input is between bursts. On the output side, each word comes out with the index of the input port that sent it. A receiver can therefore tell which requester a burst came from without any header inside the data.

Each output port has its own round-robin arbiter. The arbiter grants a whole burst to one input at a time. Once a link is granted, the input-to-output selection is reused for every word until the tail word goes through. The link then closes by itself. Arbitration therefore happens once per burst, and no part of the control logic needs to know how long a burst is. An input that is waiting for a grant asks for only one output. Because no input ever holds two pending requests, two inputs cannot deadlock each other.

Every port uses request/grant flow control: a word moves on a rising clock edge only when both request and grant are high. Each output port has a registered stage, so an input's word appears on its output two clocks after the input starts requesting an idle output. A stalled receiver holds its output word in place until it is taken.

Top module: `burst_xbar`

## Requirements
- R1: The destination index (`in_dest`, bits [i*IW +: IW] for input i) is taken only when an input with no open link requests. Values on `in_dest` during later words of the same burst have no effect, and every word of the burst reaches the output selected by the first word.
- R2: Each output word carries, unchanged, the data and tail flag accepted from its input. `out_src` equals the index of that input on every word of the burst.
- R3: Bursts are atomic. On an output, the words of one burst appear back to back and in order, with no word lost or repeated. The bursts from any one input are delivered in the order that input issued them.
- R4: Suppose an input starts requesting an idle output in cycle n. Its `in_gnt` is first high in cycle n+1, and its first word is presented on the output in cycle n+2.
- R5: Accepting a word with the tail flag set closes the link, and this includes a one-word burst. The output can then be granted to any waiting input.
- R6: When several inputs wait for one free output, the grant goes to the first requester found by searching upward from the input granted most recently, wrapping at N-1. After reset the search starts at input 0.
- R7: While `out_req` is high and `out_gnt` is low, the next cycle still shows `out_req` high with the same data, tail flag and source index.
- R8: Once a link is open and the output is always granted, a burst of L words leaves the output in L consecutive cycles.
- R9: In the cycle after reset is released, every `out_req` and every `in_gnt` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_req | input | NPORT | Per-input word valid |
| in_gnt | output | NPORT | Per-input word accepted this edge |
| in_data | input | NPORT*DW | Per-input data word, input i at [i*DW +: DW] |
| in_tail | input | NPORT | Per-input last-word flag |
| in_dest | input | NPORT*IW | Per-input destination output index |
| out_req | output | NPORT | Per-output word valid |
| out_gnt | input | NPORT | Per-output receiver accepts |
| out_data | output | NPORT*DW | Per-output data word |
| out_tail | output | NPORT | Per-output last-word flag |
| out_src | output | NPORT*IW | Per-output originating input index |

## Verification
The bench targets these corner cases:
- One-word bursts, which open and close a link with a single word. A teardown bug would leave such an output stuck, or hand it to the same input twice.
- Three inputs competing for one output through two rounds of grants. A pointer that fails to wrap, or restarts at zero every time, changes the logged order of grants from 0,1,3,0,1,3.
- Sweeps that change the destination index on every non-first word while applying irregular backpressure on the outputs. These catch a switch that re-decodes the destination mid-burst, interleaves bursts, or overwrites a stalled output word.
- The two-cycle setup latency and the one-word-per-cycle streaming rate, which are both measured directly.

// File: rtl/burst_xbar_pkg.sv
package burst_xbar_pkg;
  // Width of a port index; never less than one bit.
  function automatic int idx_w(input int n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/xbar_rr_arbiter.sv
module xbar_rr_arbiter
  import burst_xbar_pkg::*;
#(
  parameter int NREQ = 16,
  localparam int IW = idx_w(NREQ)
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NREQ-1:0] req,
  input  logic            take,
  output logic            any,
  output logic [IW-1:0]   pick
);
  logic [IW-1:0] last_q;
  logic [IW-1:0] cand;

  // Search starts one past the last winner and wraps around.
  always_comb begin
    any  = 1'b0;
    pick = '0;
    cand = '0;
    for (int k = 1; k <= NREQ; k++) begin
      cand = IW'((int'(last_q) + k) % NREQ);
      if (!any && req[cand]) begin
        any  = 1'b1;
        pick = cand;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) last_q <= IW'(NREQ - 1);
    else if (take && any) last_q <= pick;
  end
endmodule

// File: rtl/xbar_out_port.sv
module xbar_out_port
  import burst_xbar_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int DW = 36,
  localparam int IW = idx_w(NPORT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    arb_req,
  input  logic [NPORT-1:0]    in_req,
  input  logic [NPORT*DW-1:0] in_data,
  input  logic [NPORT-1:0]    in_tail,
  input  logic                out_gnt,
  output logic                link_vld,
  output logic [IW-1:0]       link_src,
  output logic                accept,
  output logic                out_req,
  output logic [DW-1:0]       out_data,
  output logic                out_tail,
  output logic [IW-1:0]       out_src
);
  logic          arb_any;
  logic [IW-1:0] arb_pick;
  logic          slot_free;
  logic          move;

  xbar_rr_arbiter #(.NREQ(NPORT)) u_arb (
    .clk (clk),
    .rst (rst),
    .req (arb_req),
    .take(!link_vld),
    .any (arb_any),
    .pick(arb_pick)
  );

  assign slot_free = !out_req || out_gnt;
  assign accept    = link_vld && slot_free;
  assign move      = accept && in_req[link_src];

  // Link state: opened by arbitration, closed by an accepted tail word.
  always_ff @(posedge clk) begin
    if (rst) begin
      link_vld <= 1'b0;
      link_src <= '0;
    end else if (!link_vld && arb_any) begin
      link_vld <= 1'b1;
      link_src <= arb_pick;
    end else if (move && in_tail[link_src]) begin
      link_vld <= 1'b0;
    end
  end

  // Registered output stage.
  always_ff @(posedge clk) begin
    if (rst) begin
      out_req  <= 1'b0;
      out_data <= '0;
      out_tail <= 1'b0;
      out_src  <= '0;
    end else if (move) begin
      out_req  <= 1'b1;
      out_data <= in_data[link_src*DW +: DW];
      out_tail <= in_tail[link_src];
      out_src  <= link_src;
    end else if (out_gnt) begin
      out_req  <= 1'b0;
    end
  end
endmodule

// File: rtl/burst_xbar.sv
module burst_xbar
  import burst_xbar_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int DW = 36,
  localparam int IW = idx_w(NPORT)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [NPORT-1:0]    in_req,
  output logic [NPORT-1:0]    in_gnt,
  input  logic [NPORT*DW-1:0] in_data,
  input  logic [NPORT-1:0]    in_tail,
  input  logic [NPORT*IW-1:0] in_dest,
  output logic [NPORT-1:0]    out_req,
  input  logic [NPORT-1:0]    out_gnt,
  output logic [NPORT*DW-1:0] out_data,
  output logic [NPORT-1:0]    out_tail,
  output logic [NPORT*IW-1:0] out_src
);
  logic [NPORT-1:0] link_vld;
  logic [NPORT-1:0] accept;
  logic [IW-1:0]    link_src [NPORT];
  logic [NPORT-1:0] arb_req  [NPORT];
  logic [NPORT-1:0] linked;

  // Which inputs own a link, and which may move a word this edge.
  always_comb begin
    linked = '0;
    in_gnt = '0;
    for (int j = 0; j < NPORT; j++) begin
      for (int i = 0; i < NPORT; i++) begin
        if (link_vld[j] && link_src[j] == IW'(i)) begin
          linked[i] = 1'b1;
          if (accept[j]) in_gnt[i] = 1'b1;
        end
      end
    end
  end

  // An unlinked input raises exactly one request, toward its destination.
  always_comb begin
    for (int j = 0; j < NPORT; j++) begin
      for (int i = 0; i < NPORT; i++) begin
        arb_req[j][i] = in_req[i] && !linked[i] && (in_dest[i*IW +: IW] == IW'(j));
      end
    end
  end

  for (genvar j = 0; j < NPORT; j++) begin : g_out
    xbar_out_port #(.NPORT(NPORT), .DW(DW)) u_port (
      .clk     (clk),
      .rst     (rst),
      .arb_req (arb_req[j]),
      .in_req  (in_req),
      .in_data (in_data),
      .in_tail (in_tail),
      .out_gnt (out_gnt[j]),
      .link_vld(link_vld[j]),
      .link_src(link_src[j]),
      .accept  (accept[j]),
      .out_req (out_req[j]),
      .out_data(out_data[j*DW +: DW]),
      .out_tail(out_tail[j]),
      .out_src (out_src[j*IW +: IW])
    );
  end
endmodule

// File: rtl/burst_xbar_chk.sv
module burst_xbar_chk
  import burst_xbar_pkg::*;
#(
  parameter int NPORT = 16,
  parameter int DW = 36,
  localparam int IW = idx_w(NPORT)
) (
  input logic                clk,
  input logic                rst,
  input logic [NPORT-1:0]    in_req,
  input logic [NPORT-1:0]    in_gnt,
  input logic [NPORT-1:0]    out_req,
  input logic [NPORT-1:0]    out_gnt,
  input logic [NPORT*DW-1:0] out_data,
  input logic [NPORT-1:0]    out_tail,
  input logic [NPORT*IW-1:0] out_src
);
  logic [NPORT-1:0] mid;
  logic [IW-1:0]    cur [NPORT];
  logic [NPORT-1:0] landed;

  always_comb begin
    landed = '0;
    for (int i = 0; i < NPORT; i++)
      for (int j = 0; j < NPORT; j++)
        if (out_req[j] && out_src[j*IW +: IW] == IW'(i)) landed[i] = 1'b1;
  end

  p_reset_idle_r9: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> (out_req == '0 && in_gnt == '0));

  for (genvar j = 0; j < NPORT; j++) begin : g_o
    always_ff @(posedge clk) begin
      if (rst) begin
        mid[j] <= 1'b0;
        cur[j] <= '0;
      end else if (out_req[j] && out_gnt[j]) begin
        mid[j] <= !out_tail[j];
        cur[j] <= out_src[j*IW +: IW];
      end
    end

    p_atomic_src_r3: assert property (@(posedge clk) disable iff (rst)
      (out_req[j] && mid[j]) |-> (out_src[j*IW +: IW] == cur[j]));

    p_stall_hold_r7: assert property (@(posedge clk) disable iff (rst)
      (out_req[j] && !out_gnt[j]) |=> (out_req[j] && $stable(out_data[j*DW +: DW])
                                        && $stable(out_tail[j]) && $stable(out_src[j*IW +: IW])));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    p_xfer_lands_r2: assert property (@(posedge clk) disable iff (rst)
      (in_req[i] && in_gnt[i]) |=> landed[i]);
  end
endmodule

bind burst_xbar burst_xbar_chk #(.NPORT(NPORT), .DW(DW)) u_chk (
  .clk(clk), .rst(rst), .in_req(in_req), .in_gnt(in_gnt), .out_req(out_req),
  .out_gnt(out_gnt), .out_data(out_data), .out_tail(out_tail), .out_src(out_src)
);

// File: tb/tb_burst_xbar.sv
module tb_burst_xbar;
  localparam int CLK_P = 10;
  localparam int NP = 4;
  localparam int DW = 12;
  localparam int IW = 2;
  localparam int MAXB = 16;
  localparam int MAXL = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [NP-1:0]    in_req = '0;
  logic [NP-1:0]    in_gnt;
  logic [NP*DW-1:0] in_data = '0;
  logic [NP-1:0]    in_tail = '0;
  logic [NP*IW-1:0] in_dest = '0;
  logic [NP-1:0]    out_req;
  logic [NP-1:0]    out_gnt = '0;
  logic [NP*DW-1:0] out_data;
  logic [NP-1:0]    out_tail;
  logic [NP*IW-1:0] out_src;

  burst_xbar #(.NPORT(NP), .DW(DW)) dut (
    .clk(clk), .rst(rst), .in_req(in_req), .in_gnt(in_gnt), .in_data(in_data),
    .in_tail(in_tail), .in_dest(in_dest), .out_req(out_req), .out_gnt(out_gnt),
    .out_data(out_data), .out_tail(out_tail), .out_src(out_src)
  );

  always #(CLK_P/2) clk = ~clk;

  int checks = 0;
  int fails = 0;

  // Burst tables and bookkeeping.
  int t_dest [NP][MAXB];
  int t_len  [NP][MAXB];
  int t_gap  [NP][MAXB];
  int nb [NP];
  int bidx [NP];
  int widx [NP];
  int gapc [NP];
  int st0 [NP];
  int fg [NP];
  int nq [NP];
  int log_n [NP];
  int log_src [NP][MAXL];
  int log_ft [NP][MAXL];
  int log_tt [NP][MAXL];
  bit mid [NP];
  int cur_s [NP];
  int cur_q [NP];
  int nxt_k [NP];
  bit ps [NP];
  logic [DW+IW:0] pd [NP];
  int exp_words;
  int rx_words;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] enc(input int s, input int q, input int k);
    return DW'((s << 7) | (q << 3) | k);
  endfunction

  task automatic clear_tables();
    for (int i = 0; i < NP; i++) nb[i] = 0;
    exp_words = 0;
  endtask

  task automatic add_burst(input int i, input int d, input int l, input int g);
    t_dest[i][nb[i]] = d;
    t_len[i][nb[i]]  = l;
    t_gap[i][nb[i]]  = g;
    nb[i]++;
    exp_words += l;
  endtask

  task automatic monitor(input int tick);
    for (int j = 0; j < NP; j++) begin
      logic [DW-1:0] w;
      int k, q, s, src;
      w = out_data[j*DW +: DW];
      if (ps[j]) chk(out_req[j] && {out_tail[j], out_src[j*IW +: IW], w} == pd[j],
                     "R7 stalled word changed", int'(w), int'(pd[j][DW-1:0]));
      ps[j] = out_req[j] && !out_gnt[j];
      pd[j] = {out_tail[j], out_src[j*IW +: IW], w};
      if (out_req[j] && out_gnt[j]) begin
        k = int'(w[2:0]);
        q = int'(w[6:3]);
        s = int'(w[8:7]);
        src = int'(out_src[j*IW +: IW]);
        rx_words++;
        chk(src == s, "R2 source index", src, s);
        chk(t_dest[s][q] == j, "R1 output choice", j, t_dest[s][q]);
        chk(out_tail[j] == (k == t_len[s][q] - 1), "R2 tail flag", int'(out_tail[j]), int'(k == t_len[s][q] - 1));
        if (mid[j]) begin
          chk(s == cur_s[j] && q == cur_q[j] && k == nxt_k[j], "R3 burst continuity",
              (s << 8) | (q << 4) | k, (cur_s[j] << 8) | (cur_q[j] << 4) | nxt_k[j]);
        end else begin
          chk(k == 0, "R3 burst start word", k, 0);
          chk(q == nq[s], "R3 per-input burst order", q, nq[s]);
          nq[s] = q + 1;
          if (log_n[j] < MAXL) begin
            log_src[j][log_n[j]] = s;
            log_ft[j][log_n[j]] = tick;
          end
          log_n[j]++;
        end
        if (out_tail[j]) begin
          mid[j] = 1'b0;
          if (log_n[j] <= MAXL) log_tt[j][log_n[j]-1] = tick;
        end else begin
          mid[j] = 1'b1;
          cur_s[j] = s;
          cur_q[j] = q;
          nxt_k[j] = k + 1;
        end
      end
    end
  endtask

  task automatic run_test(input int mode, input int maxt);
    int tick, quiet;
    bit busy;
    logic [NP-1:0] g;
    rst = 1'b1;
    in_req = '0;
    out_gnt = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk(out_req == '0, "R9 out_req after reset", int'(out_req), 0);
    chk(in_gnt == '0, "R9 in_gnt after reset", int'(in_gnt), 0);
    for (int i = 0; i < NP; i++) begin
      bidx[i] = 0; widx[i] = 0; st0[i] = -1; fg[i] = -1; nq[i] = 0;
      gapc[i] = (nb[i] > 0) ? t_gap[i][0] : 0;
      log_n[i] = 0; mid[i] = 1'b0; ps[i] = 1'b0;
    end
    rx_words = 0;
    tick = 0;
    quiet = 0;
    @(negedge clk);
    while (quiet < 3 && tick < maxt) begin
      for (int i = 0; i < NP; i++) begin
        if (bidx[i] < nb[i] && gapc[i] == 0) begin
          in_req[i] = 1'b1;
          in_data[i*DW +: DW] = enc(i, bidx[i], widx[i]);
          in_tail[i] = (widx[i] == t_len[i][bidx[i]] - 1);
          in_dest[i*IW +: IW] = (widx[i] == 0) ? IW'(t_dest[i][bidx[i]]) : IW'(t_dest[i][bidx[i]] ^ 1);
          if (bidx[i] == 0 && widx[i] == 0 && st0[i] < 0) st0[i] = tick;
        end else begin
          in_req[i] = 1'b0;
        end
      end
      for (int j = 0; j < NP; j++)
        out_gnt[j] = (mode == 0) ? 1'b1 : (((tick + 2*j) % 5 != 0) && (tick % 7 != 3));
      #1;
      g = in_gnt;
      monitor(tick);
      busy = 1'b0;
      for (int i = 0; i < NP; i++) begin
        if (in_req[i] && g[i]) begin
          if (fg[i] < 0) fg[i] = tick;
          if (in_tail[i]) begin
            bidx[i]++;
            widx[i] = 0;
            gapc[i] = (bidx[i] < nb[i]) ? t_gap[i][bidx[i]] : 0;
          end else begin
            widx[i]++;
          end
        end else if (bidx[i] < nb[i] && gapc[i] > 0) begin
          gapc[i]--;
        end
        if (bidx[i] < nb[i]) busy = 1'b1;
      end
      if (busy || out_req != '0) quiet = 0;
      else quiet++;
      tick++;
      @(negedge clk);
    end
    in_req = '0;
    chk(rx_words == exp_words, "R3 word count", rx_words, exp_words);
    chk(tick < maxt, "R3 all bursts completed", tick, maxt);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    // Setup latency, single-word bursts, reopening after teardown (R4, R5).
    clear_tables();
    add_burst(0, 2, 1, 0);
    add_burst(1, 2, 1, 3);
    run_test(0, 200);
    chk(log_n[2] == 2, "R5 bursts on output 2", log_n[2], 2);
    chk(log_src[2][0] == 0, "R5 first owner", log_src[2][0], 0);
    chk(log_src[2][1] == 1, "R5 output reopened", log_src[2][1], 1);
    chk(fg[0] - st0[0] == 1, "R4 grant latency", fg[0] - st0[0], 1);
    chk(log_ft[2][0] - st0[0] == 2, "R4 output latency", log_ft[2][0] - st0[0], 2);

    // Round-robin with wraparound (R6).
    clear_tables();
    for (int r = 0; r < 2; r++) begin
      add_burst(0, 1, 2, 0);
      add_burst(1, 1, 2, 0);
      add_burst(3, 1, 2, 0);
    end
    run_test(0, 200);
    chk(log_n[1] == 6, "R6 burst count", log_n[1], 6);
    for (int k = 0; k < 6; k++) begin
      int e;
      e = (k % 3 == 2) ? 3 : (k % 3);
      chk(log_src[1][k] == e, "R6 grant order", log_src[1][k], e);
    end

    // Streaming rate once linked (R8).
    clear_tables();
    add_burst(2, 0, 5, 0);
    run_test(0, 200);
    chk(log_tt[0][0] - log_ft[0][0] == 4, "R8 words per cycle", log_tt[0][0] - log_ft[0][0], 4);

    // Full sweeps, with and without output backpressure (R1, R2, R3, R7).
    for (int mode = 1; mode >= 0; mode--) begin
      clear_tables();
      for (int i = 0; i < NP; i++)
        for (int b = 0; b < 12; b++)
          add_burst(i, (i + b*3 + b/4 + mode) % NP, 1 + (i*2 + b) % 5, ((i + b) % 3 == 0) ? 1 : 0);
      run_test(mode, 3000);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule